// File: doc/BRIEF.md
# Nibble ALU with decimal correction

This block is the arithmetic and logic unit of a small CPU that works on 4-bit data. Each operation is issued by a one-cycle strobe along with two operands, a carry input, an operation code, a destination tag and the decimal-mode flag. The block registers a 4-bit result and carry and zero flags, and signals completion one clock later.

When decimal mode is set, add and subtract results are adjusted so that they stay valid BCD digits. Some operations are never adjusted, whatever the mode. These are compare, increment and decrement, and any add or subtract whose destination is one nibble of an 8-bit index register. The result is only meaningful for BCD operands (0 to 9). Logic operations ignore decimal mode and leave the carry flag untouched. Compare updates the flags and keeps the previous result.

Top module: `nibble_alu`

## Requirements
- R1: While rst_n is low, result, carry, zero, done and wrote are all 0.
- R2: An issue pulse in cycle n raises done for cycle n+1 only, and result, carry and zero take their new values at that same edge.
- R3: With decimal mode off, ADD (code 0) gives a+b, ADC (1) gives a+b+carry_in, SUB (2) gives a-b and SBC (3) gives a-b-carry_in, all modulo 16. Carry is set on carry-out for ADC/ADD and on borrow for SUB/SBC. carry_in is ignored by all other codes.
- R4: With decimal mode on and idx_dst low, if the binary sum of ADD/ADC is above 9, the result is (sum+6) modulo 16 and carry is 1. Otherwise the result is the binary sum and carry is 0.
- R5: With decimal mode on and idx_dst low, if SUB/SBC borrows, the result is (difference-6) modulo 16 and carry is 1. Otherwise the result is the binary difference and carry is 0.
- R6: With idx_dst high, codes 0 to 3 give the binary result and carry even when decimal mode is on.
- R7: CMP (code 4) forms a binary a-b in every mode. It sets carry on borrow and sets zero when a equals b. It keeps result unchanged and holds wrote low.
- R8: INC (code 5) gives a+1 and DEC (code 6) gives a-1, modulo 16, in any mode and with no decimal adjustment. Carry marks the carry-out of INC or the borrow of DEC.
- R9: AND (7), OR (8) and XOR (9) write the bitwise result and update zero. Carry keeps its previous value and decimal mode has no effect.
- R10: For every code that writes a result, zero equals 1 exactly when the final 4-bit result, after any adjustment, is 0000. wrote is high with done for codes 0 to 3 and 5 to 9.
- R11: Codes 10 to 15 change neither result, carry nor zero. done still pulses and wrote stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Start one operation this cycle |
| op_code | input | 4 | Operation code |
| idx_dst | input | 1 | Destination is an index-register nibble |
| dec_mode | input | 1 | Decimal mode flag |
| opnd_a | input | 4 | First operand |
| opnd_b | input | 4 | Second operand |
| carry_in | input | 1 | Carry used by ADC and SBC |
| result | output | 4 | Registered result |
| carry | output | 1 | Carry / borrow flag |
| zero | output | 1 | Zero flag |
| done | output | 1 | Operation completed in the previous cycle |
| wrote | output | 1 | The completed operation wrote result |

## Verification
The hardest cases to reach are the adjustments at the edges of the digit range. One is a decimal add that wraps past 15, where the +6 must still be applied to the low nibble. The other is a decimal subtract with borrow-in that lands exactly on -1 or -10. The stimulus drives these points on purpose: 9+9+1 and 5+5, and 2-2-1 and 0-9-1. It repeats the same operand pairs with idx_dst high so that the suppressed and adjusted answers differ. Logic operations follow both carry-setting and carry-clearing operations, so the held carry is seen with both values.

// File: rtl/nibble_alu.sv
module nibble_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue,
  input  logic [3:0] op_code,
  input  logic       idx_dst,
  input  logic       dec_mode,
  input  logic [3:0] opnd_a,
  input  logic [3:0] opnd_b,
  input  logic       carry_in,
  output logic [3:0] result,
  output logic       carry,
  output logic       zero,
  output logic       done,
  output logic       wrote
);

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBC = 4'd3;
  localparam logic [3:0] OP_CMP = 4'd4;
  localparam logic [3:0] OP_INC = 4'd5;
  localparam logic [3:0] OP_DEC = 4'd6;
  localparam logic [3:0] OP_AND = 4'd7;
  localparam logic [3:0] OP_OR  = 4'd8;
  localparam logic [3:0] OP_XOR = 4'd9;

  logic       cin_used;
  logic       adjust;
  logic [4:0] sum_w;
  logic [4:0] dif_w;
  logic [3:0] n_res;
  logic       n_car;
  logic       n_zer;
  logic       n_wr;

  assign cin_used = ((op_code == OP_ADC) || (op_code == OP_SBC)) && carry_in;
  assign adjust   = dec_mode && !idx_dst;
  assign sum_w    = {1'b0, opnd_a} + {1'b0, opnd_b} + {4'b0, cin_used};
  assign dif_w    = {1'b0, opnd_a} - {1'b0, opnd_b} - {4'b0, cin_used};

  always_comb begin
    n_res = result;
    n_car = carry;
    n_zer = zero;
    n_wr  = 1'b0;
    case (op_code)
      OP_ADD, OP_ADC: begin
        n_wr = 1'b1;
        if (adjust && (sum_w > 5'd9)) begin
          n_res = sum_w[3:0] + 4'd6;
          n_car = 1'b1;
        end else begin
          n_res = sum_w[3:0];
          n_car = sum_w[4];
        end
      end
      OP_SUB, OP_SBC: begin
        n_wr = 1'b1;
        if (adjust && dif_w[4]) n_res = dif_w[3:0] - 4'd6;
        else                    n_res = dif_w[3:0];
        n_car = dif_w[4];
      end
      OP_CMP: begin
        n_car = dif_w[4];
        n_zer = (dif_w[3:0] == 4'd0);
      end
      OP_INC: begin
        n_wr = 1'b1;
        {n_car, n_res} = {1'b0, opnd_a} + 5'd1;
      end
      OP_DEC: begin
        n_wr = 1'b1;
        {n_car, n_res} = {1'b0, opnd_a} - 5'd1;
      end
      OP_AND: begin n_wr = 1'b1; n_res = opnd_a & opnd_b; end
      OP_OR:  begin n_wr = 1'b1; n_res = opnd_a | opnd_b; end
      OP_XOR: begin n_wr = 1'b1; n_res = opnd_a ^ opnd_b; end
      default: ;
    endcase
    if (n_wr) n_zer = (n_res == 4'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= 4'd0;
      carry  <= 1'b0;
      zero   <= 1'b0;
      done   <= 1'b0;
      wrote  <= 1'b0;
    end else begin
      done  <= issue;
      wrote <= issue && n_wr;
      if (issue) begin
        result <= n_res;
        carry  <= n_car;
        zero   <= n_zer;
      end
    end
  end

endmodule

// File: rtl/nibble_alu_chk.sv
module nibble_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       issue,
  input logic [3:0] op_code,
  input logic       idx_dst,
  input logic       dec_mode,
  input logic [3:0] opnd_a,
  input logic [3:0] opnd_b,
  input logic [3:0] result,
  input logic       carry,
  input logic       zero,
  input logic       done,
  input logic       wrote
);

  // R2
  done_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> done);

  // R2
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> !done);

  // R4
  bcd_sum_stays_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_mode && !idx_dst && op_code == 4'd0 && opnd_a <= 4'd9 && opnd_b <= 4'd9)
    |=> (result <= 4'd9));

  // R6
  index_add_binary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && idx_dst && op_code == 4'd0)
    |=> (result == 4'($past(opnd_a) + $past(opnd_b))));

  // R7
  compare_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op_code == 4'd4) |=> ($stable(result) && !wrote));

  // R8
  inc_never_adjusted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op_code == 4'd5) |=> (result == 4'($past(opnd_a) + 4'd1)));

  // R9
  logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op_code >= 4'd7 && op_code <= 4'd9) |=> $stable(carry));

  // R10
  zero_matches_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wrote) |-> (zero == (result == 4'd0)));

  // R11
  unused_code_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op_code >= 4'd10)
    |=> ($stable(result) && $stable(carry) && $stable(zero) && !wrote));

endmodule

bind nibble_alu nibble_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .op_code(op_code),
  .idx_dst(idx_dst), .dec_mode(dec_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .result(result), .carry(carry), .zero(zero), .done(done), .wrote(wrote)
);

// File: tb/tb_nibble_alu.sv
module tb_nibble_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic       idx_dst = 1'b0;
  logic       dec_mode = 1'b0;
  logic [3:0] opnd_a = 4'd0;
  logic [3:0] opnd_b = 4'd0;
  logic       carry_in = 1'b0;
  logic [3:0] result;
  logic       carry, zero, done, wrote;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [6:0] exp_q[$];
  string      tag_q[$];

  int m_res = 0;
  bit m_car = 1'b0;
  bit m_zer = 1'b0;

  nibble_alu dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op_code(op_code),
    .idx_dst(idx_dst), .dec_mode(dec_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .carry_in(carry_in), .result(result), .carry(carry), .zero(zero),
    .done(done), .wrote(wrote)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int code, input int a, input int b, input bit cin,
                        input bit idx, input bit dec, input string tag);
    int  r;
    int  s;
    bit  wr;
    wr = 1'b1;
    r  = m_res;
    case (code)
      0, 1: begin
        s = a + b + ((code == 1) ? int'(cin) : 0);
        if (dec && !idx && s > 9) begin r = (s + 6) % 16; m_car = 1'b1; end
        else begin r = s % 16; m_car = (s > 15); end
      end
      2, 3: begin
        s = a - b - ((code == 3) ? int'(cin) : 0);
        m_car = (s < 0);
        if (dec && !idx && s < 0) r = (s + 32 - 6) % 16;
        else r = (s + 16) % 16;
      end
      4: begin wr = 1'b0; m_car = (a < b); m_zer = (a == b); end
      5: begin r = (a + 1) % 16; m_car = (a == 15); end
      6: begin r = (a + 15) % 16; m_car = (a == 0); end
      7: r = a & b;
      8: r = a | b;
      9: r = a ^ b;
      default: wr = 1'b0;
    endcase
    if (wr) begin m_res = r; m_zer = (r == 0); end
    exp_q.push_back({wr, m_zer, m_car, 4'(m_res)});
    tag_q.push_back(tag);
    @(negedge clk);
    op_code = 4'(code); opnd_a = 4'(a); opnd_b = 4'(b);
    carry_in = cin; idx_dst = idx; dec_mode = dec; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    @(posedge clk); #(CLK_PERIOD/4);
    check({tag, " R2 done drop"}, int'(done), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk); #(CLK_PERIOD/4);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected done", 1, 0);
        end else begin
          logic [6:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " result"}, int'(result), int'(e[3:0]));
          check({t, " carry"},  int'(carry),  int'(e[4]));
          check({t, " zero"},   int'(zero),   int'(e[5]));
          check({t, " R10 wrote"}, int'(wrote), int'(e[6]));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result", int'(result), 0);
    check("R1 carry", int'(carry), 0);
    check("R1 zero", int'(zero), 0);
    check("R1 done", int'(done), 0);
    check("R1 wrote", int'(wrote), 0);
    rst_n = 1'b1;

    run_op(0, 3, 4, 1'b1, 0, 0, "R3 add");
    run_op(0, 9, 8, 0, 0, 0, "R3 add carry");
    run_op(1, 15, 0, 1, 0, 0, "R3 adc wrap");
    run_op(2, 5, 7, 1, 0, 0, "R3 sub borrow");
    run_op(3, 8, 3, 1, 0, 0, "R3 sbc");
    run_op(7, 12, 10, 0, 0, 1, "R9 and carry0");
    run_op(4'd5, 15, 0, 0, 0, 0, "R8 inc wrap");
    run_op(8, 4, 2, 0, 0, 1, "R9 or carry1");
    run_op(9, 5, 5, 0, 0, 0, "R9 xor zero");

    run_op(0, 5, 4, 0, 0, 1, "R4 dec add no adj");
    run_op(0, 7, 5, 0, 0, 1, "R4 dec add adj");
    run_op(1, 9, 9, 1, 0, 1, "R4 dec adc 19");
    run_op(0, 5, 5, 0, 0, 1, "R10 dec add zero");
    run_op(2, 3, 5, 0, 0, 1, "R5 dec sub");
    run_op(3, 2, 2, 1, 0, 1, "R5 dec sbc -1");
    run_op(3, 0, 9, 1, 0, 1, "R5 dec sbc -10");
    run_op(2, 9, 4, 0, 0, 1, "R5 dec sub no borrow");

    run_op(1, 7, 5, 0, 1, 1, "R6 idx adc");
    run_op(0, 9, 9, 0, 1, 1, "R6 idx add");
    run_op(2, 3, 5, 0, 1, 1, "R6 idx sub");

    run_op(4, 6, 6, 1, 0, 1, "R7 cmp equal");
    run_op(4, 2, 9, 0, 0, 1, "R7 cmp borrow");
    run_op(4, 9, 2, 0, 0, 0, "R7 cmp greater");

    run_op(5, 9, 0, 0, 0, 1, "R8 dec-mode inc");
    run_op(6, 0, 0, 0, 0, 1, "R8 dec-mode dec");
    run_op(6, 10, 0, 1, 0, 0, "R8 dec");

    run_op(12, 3, 3, 1, 0, 1, "R11 unused 12");
    run_op(15, 0, 0, 0, 0, 0, "R11 unused 15");
    run_op(7, 0, 15, 0, 0, 0, "R10 and zero");

    repeat (3) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule